// File: doc/BRIEF.md
# Configuration Image Streaming Controller

This block moves a stored configuration image out of an on-chip synchronous memory and into a 32-bit internal configuration port. It needs no processor and no bus. User logic picks an image with a selector input and then raises a trigger. The controller then enables the port for writing and fetches words from memory. It places one word on the port data input in every clock cycle the port can accept it.

The transfer does not count to a fixed length. The controller inspects every word as it leaves and stops after sending the end-of-configuration (desynchronise) command word. It also watches the port's read-back bus and stops if that bus changes from 0xDF to 0x9F, which shows that the port has already taken the command.

Each image occupies its own fixed-size region of memory. A guard stops a runaway transfer at the end of that region and raises an error flag. A cycle counter records how many cycles the port was enabled, which gives the reconfiguration time: word count plus stall cycles, divided by the clock rate.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `port_ce_n_o` and `port_wr_n_o` are 1, `done_n_o` is 1, `err_o` is 0, `xfer_cycles_o` is 0 and `mem_en_o` is 0.
- R2: When `trig_i` is high in the idle state, the next cycle is a memory prefetch: `mem_en_o` is 1, `mem_addr_o` is the image base and the port is still disabled. In the cycle after that, `port_ce_n_o` and `port_wr_n_o` are both 0 and `port_din_o` carries the image's first word.
- R3: While `port_busy_i` is low, the words reach `port_din_o` in ascending memory order, one per cycle, with no idle cycles between them. A word counts as sent in a cycle where `port_ce_n_o` is 0 and `port_busy_i` is 0.
- R4: Sending a word equal to END_WORD (default 32'h0000000D) ends the transfer. At the next clock edge `port_ce_n_o` and `port_wr_n_o` go to 1 and `done_n_o` goes to 0. A single-word image and an image whose end word is the last word of its region both work.
- R5: While `port_busy_i` is high during a transfer, `port_din_o` holds its word, the port stays enabled and the read address does not advance.
- R6: During a transfer, if `port_dout_i` reads 32'h000000DF in one cycle and 32'h0000009F in the next, the transfer ends at the close of that second cycle. The word presented in that cycle counts as sent if `port_busy_i` is low.
- R7: `img_sel_i` chooses the image whose base address is `img_sel_i * IMG_SPAN`. It is sampled only when a transfer starts, and later changes do not affect the running transfer.
- R8: After a transfer ends, no new transfer starts until `trig_i` has been seen low. A trigger that drops and rises again during a transfer has no effect on it.
- R9: If the word at offset IMG_SPAN-1 of the region is sent and it is not the end word, the transfer ends with `err_o` = 1 and `done_n_o` = 0.
- R10: `xfer_cycles_o` clears when a transfer starts, counts every cycle with `port_ce_n_o` = 0 (stall cycles included), and holds its value after the transfer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller, memory and port |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start request from user logic |
| img_sel_i | input | SEL_W (2) | Image number to load |
| mem_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W (8) | Memory read address |
| mem_rdata_i | input | DATA_W (32) | Memory read data, one cycle after the enabled address; held while not enabled |
| port_ce_n_o | output | 1 | Active-low configuration port select |
| port_wr_n_o | output | 1 | Active-low write select |
| port_din_o | output | DATA_W (32) | Word presented to the port |
| port_dout_i | input | DATA_W (32) | Port read-back/status bus |
| port_busy_i | input | 1 | Active-high port busy; the port refuses the word |
| done_n_o | output | 1 | Active-low transfer-finished indicator |
| err_o | output | 1 | Region exhausted without an end word |
| xfer_cycles_o | output | CNT_W (16) | Enabled-port cycles of the last transfer |

## Verification
The assertions check the following on every cycle:
- a stalled word stays on the port, and the port stays enabled, while busy is high;
- the read address holds during a stall and steps by one on each issue;
- the port is released and done is raised right after the end word is accepted;
- a held trigger never reopens the port once the transfer has finished.

Only the bench scenarios can show the following:
- the exact order and content of the stream for each selected image;
- the length of each transfer, including the single-word and last-offset edge cases, and the error when the region is exhausted;
- an early finish caused by the read-back status change;
- that a selector change or a trigger glitch in mid-transfer has no effect.

// File: rtl/cfg_stream_pkg.sv
`timescale 1ns/1ps
package cfg_stream_pkg;

  typedef enum logic [1:0] {
    ST_BEGIN  = 2'd0,
    ST_PRIME  = 2'd1,
    ST_CONFIG = 2'd2,
    ST_DONE   = 2'd3
  } xfer_state_t;

  localparam logic [31:0] STATUS_SYNCED = 32'h0000_00DF;
  localparam logic [31:0] STATUS_DESYNC = 32'h0000_009F;

endpackage

// File: rtl/cfg_addr_gen.sv
`timescale 1ns/1ps
module cfg_addr_gen #(
  parameter int ADDR_W   = 8,
  parameter int SEL_W    = 2,
  parameter int IMG_SPAN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              issue_i,
  input  logic              accept_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_o
);

  localparam int OFF_W = (IMG_SPAN > 1) ? $clog2(IMG_SPAN) : 1;
  localparam int CNT_W = OFF_W + 1;
  localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(IMG_SPAN - 1);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [CNT_W-1:0]  wcnt_q;

  generate
    if ((IMG_SPAN & (IMG_SPAN - 1)) == 0) begin : g_pow2_base
      assign base = ADDR_W'({sel_i, {OFF_W{1'b0}}});
    end else begin : g_mul_base
      assign base = ADDR_W'(sel_i) * ADDR_W'(IMG_SPAN);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else if (load_i) begin
      rd_addr_q <= base;
    end else if (issue_i) begin
      rd_addr_q <= rd_addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (load_i) begin
      wcnt_q <= '0;
    end else if (accept_i) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign rd_addr_o = rd_addr_q;
  assign last_o    = (wcnt_q == LAST_OFF);

  // R5: no issue means the address stays put
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !issue_i) |=> $stable(rd_addr_o));

  // R3: each issue steps the address by exactly one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && issue_i) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));

endmodule

// File: rtl/cfg_end_detect.sv
`timescale 1ns/1ps
module cfg_end_detect
  import cfg_stream_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] END_WORD = 32'h0000_000D,
  parameter bit              USE_STATUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              word_is_end_o,
  output logic              status_end_o
);

  assign word_is_end_o = (word_i == END_WORD);

  generate
    if (USE_STATUS) begin : g_status
      logic [DATA_W-1:0] stat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= '0;
        end else begin
          stat_q <= status_i;
        end
      end

      assign status_end_o = (stat_q == DATA_W'(STATUS_SYNCED)) &&
                            (status_i == DATA_W'(STATUS_DESYNC));
    end else begin : g_no_status
      assign status_end_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfg_xfer_timer.sv
`timescale 1ns/1ps
module cfg_xfer_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R10: a counted cycle adds one
  p_timer_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (cnt_o != CNT_MAX)) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R10: idle cycles leave the count alone
  p_timer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/cfg_stream_ctrl.sv
`timescale 1ns/1ps
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 8,
  parameter int                NUM_IMG    = 4,
  parameter int                IMG_SPAN   = 64,
  parameter int                CNT_W      = 16,
  parameter logic [DATA_W-1:0] END_WORD   = 32'h0000_000D,
  parameter bit                USE_STATUS = 1'b1,
  localparam int               SEL_W      = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [SEL_W-1:0]  img_sel_i,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              port_ce_n_o,
  output logic              port_wr_n_o,
  output logic [DATA_W-1:0] port_din_o,
  input  logic [DATA_W-1:0] port_dout_i,
  input  logic              port_busy_i,
  output logic              done_n_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  xfer_cycles_o
);

  xfer_state_t state_q, state_d;

  logic start, streaming, accept, finish, err_set, issue;
  logic word_is_end, status_end, last_word;
  logic done_q, err_q;

  // ---------------- control decode ----------------
  assign start     = (state_q == ST_BEGIN) && trig_i;
  assign streaming = (state_q == ST_CONFIG);
  assign accept    = streaming && !port_busy_i;
  assign finish    = streaming &&
                     ((accept && (word_is_end || last_word)) || status_end);
  assign err_set   = accept && last_word && !word_is_end && !status_end;
  assign issue     = (state_q == ST_PRIME) || (accept && !finish);

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BEGIN:  if (trig_i)  state_d = ST_PRIME;
      ST_PRIME:               state_d = ST_CONFIG;
      ST_CONFIG: if (finish)  state_d = ST_DONE;
      ST_DONE:   if (!trig_i) state_d = ST_BEGIN;
      default:                state_d = ST_BEGIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BEGIN;
    end else begin
      state_q <= state_d;
    end
  end

  // ---------------- result flags ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (finish)  done_q <= 1'b1;
      if (err_set) err_q  <= 1'b1;
    end
  end

  // ---------------- sub-blocks ----------------
  cfg_addr_gen #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .IMG_SPAN (IMG_SPAN)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start),
    .sel_i     (img_sel_i),
    .issue_i   (issue),
    .accept_i  (accept),
    .rd_addr_o (mem_addr_o),
    .last_o    (last_word)
  );

  cfg_end_detect #(
    .DATA_W     (DATA_W),
    .END_WORD   (END_WORD),
    .USE_STATUS (USE_STATUS)
  ) u_end (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_i        (mem_rdata_i),
    .status_i      (port_dout_i),
    .word_is_end_o (word_is_end),
    .status_end_o  (status_end)
  );

  cfg_xfer_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start),
    .inc_i (streaming),
    .cnt_o (xfer_cycles_o)
  );

  // ---------------- outputs ----------------
  assign mem_en_o    = issue;
  assign port_ce_n_o = !streaming;
  assign port_wr_n_o = !streaming;
  assign port_din_o  = mem_rdata_i;
  assign done_n_o    = !done_q;
  assign err_o       = err_q;

  // ---------------- assertions ----------------
  // R2: a start is followed by a prefetch cycle with the port still closed
  p_start_prime_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_en_o && port_ce_n_o));

  // R5: a refused word stays on the enabled port
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_ce_n_o && port_busy_i && !status_end) |=>
      (!port_ce_n_o && $stable(port_din_o)));

  // R4: an accepted end word releases the port and signals done
  p_end_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_ce_n_o && !port_busy_i && (port_din_o == END_WORD)) |=>
      (port_ce_n_o && port_wr_n_o && !done_n_o));

  // R8: a trigger still held after the finish does not reopen the port
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DONE) && trig_i) |=> port_ce_n_o);

  // R9: the error flag only rises together with the finish
  p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !done_n_o);

endmodule

// File: tb/cfg_stream_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_stream_ctrl_tb_top;

  localparam int          SPAN  = 64;
  localparam int          NIMG  = 4;
  localparam logic [31:0] ENDW  = 32'h0000_000D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [1:0]  img_sel;
  logic        mem_en;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata;
  logic        ce_n, wr_n;
  logic [31:0] din;
  logic [31:0] dout;
  logic        busy;
  logic        done_n, err;
  logic [15:0] cycles;

  always #2 clk = ~clk;

  cfg_stream_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_i        (trig),
    .img_sel_i     (img_sel),
    .mem_en_o      (mem_en),
    .mem_addr_o    (mem_addr),
    .mem_rdata_i   (mem_rdata),
    .port_ce_n_o   (ce_n),
    .port_wr_n_o   (wr_n),
    .port_din_o    (din),
    .port_dout_i   (dout),
    .port_busy_i   (busy),
    .done_n_o      (done_n),
    .err_o         (err),
    .xfer_cycles_o (cycles)
  );

  // ---------------- image store model ----------------
  logic [31:0] rom [SPAN*NIMG];
  int          elen  [NIMG];
  bit          noend [NIMG];

  always @(posedge clk) if (mem_en) mem_rdata <= rom[mem_addr];

  function automatic logic [31:0] word_at(int img, int k);
    return {4'h1, 4'(img), 8'(k), 16'(k * 37 + img * 11 + 5)};
  endfunction

  function automatic logic [31:0] exp_word(int img, int k);
    if (!noend[img] && k == elen[img] - 1) return ENDW;
    return word_at(img, k);
  endfunction

  task automatic fill_rom();
    for (int i = 0; i < NIMG; i++)
      for (int k = 0; k < SPAN; k++)
        rom[i*SPAN + k] = exp_word(i, k);
  endtask

  // ---------------- bookkeeping ----------------
  int vectors = 0;
  int fails   = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // ---------------- port monitor (R3, R5, R7) ----------------
  int mon_sel    = 0;
  int sent_cnt   = 0;
  int ce_low_cnt = 0;
  int stall_cnt  = 0;

  always @(negedge clk) begin
    if (rst_n && !ce_n) begin
      ce_low_cnt++;
      if (busy) begin
        stall_cnt++;
      end else begin
        chk(din == exp_word(mon_sel, sent_cnt), "R3/R7 stream word", din,
            exp_word(mon_sel, sent_cnt));
        sent_cnt++;
      end
    end
  end

  // ---------------- busy driver ----------------
  bit busy_rand = 1'b0;
  always @(posedge clk) begin
    #1;
    busy = busy_rand && ($urandom_range(3) == 0);
  end

  // ---------------- transfer tasks ----------------
  task automatic start_xfer(int sel);
    @(posedge clk); #1;
    img_sel    = 2'(sel);
    mon_sel    = sel;
    sent_cnt   = 0;
    ce_low_cnt = 0;
    stall_cnt  = 0;
    trig       = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_en === 1'b1 && ce_n === 1'b1 && mem_addr == 8'(sel * SPAN),
        "R2 prefetch", {24'h0, mem_addr}, 32'(sel * SPAN));
    @(negedge clk);
    chk(ce_n === 1'b0 && wr_n === 1'b0 && din == exp_word(sel, 0),
        "R2 first word", din, exp_word(sel, 0));
  endtask

  task automatic wait_done();
    int guard = 0;
    while (done_n !== 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R4 transfer ends", 32'(guard), 32'd0);
  endtask

  task automatic after_done(int held_cycles);
    // R8: trigger still high, no restart
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ce_n === 1'b1 && mem_en === 1'b0, "R8 no restart while trigger held",
          {31'h0, ce_n}, 32'd1);
    end
    @(posedge clk); #1;
    trig = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done_n === 1'b0 && cycles == 16'(held_cycles), "R10 count held after finish",
        {16'h0, cycles}, 32'(held_cycles));
  endtask

  task automatic run_xfer(int sel, bit glitch);
    int  exp_len;
    bit  exp_err;
    exp_err = noend[sel];
    exp_len = noend[sel] ? SPAN : elen[sel];
    start_xfer(sel);
    if (glitch) begin
      // R7 and R8: selector change and trigger drop mid-transfer
      @(posedge clk); #1;
      img_sel = 2'(sel ^ 1);
      trig    = 1'b0;
      @(posedge clk); #1;
      trig    = 1'b1;
    end
    wait_done();
    chk(sent_cnt == exp_len, "R4 words sent", 32'(sent_cnt), 32'(exp_len));
    chk(ce_n === 1'b1 && wr_n === 1'b1, "R4 port released", {30'h0, ce_n, wr_n}, 32'd3);
    chk(err === exp_err, "R9 error flag", {31'h0, err}, {31'h0, exp_err});
    chk(cycles == 16'(ce_low_cnt), "R10 enabled cycles", {16'h0, cycles}, 32'(ce_low_cnt));
    chk(cycles == 16'(exp_len + stall_cnt), "R5/R10 words plus stalls", {16'h0, cycles},
        32'(exp_len + stall_cnt));
    after_done(exp_len + stall_cnt);
  endtask

  task automatic run_status(int sel, int k_words);
    int c = 0;
    busy_rand = 1'b0;
    dout      = 32'h0000_00DF;
    start_xfer(sel);
    c = 1;
    if (c == k_words) dout = 32'h0000_009F;
    while (c < k_words) begin
      @(posedge clk); #1;
      if (!ce_n) c++;
      if (c == k_words) dout = 32'h0000_009F;
    end
    wait_done();
    dout = 32'h0;
    chk(sent_cnt == k_words, "R6 status end words sent", 32'(sent_cnt), 32'(k_words));
    chk(err === 1'b0 && ce_n === 1'b1, "R6 status end clean finish", {31'h0, err}, 32'd0);
    chk(cycles == 16'(k_words), "R6/R10 status end cycles", {16'h0, cycles}, 32'(k_words));
    after_done(k_words);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    trig    = 1'b0;
    img_sel = 2'd0;
    dout    = 32'h0;
    busy    = 1'b0;
    elen    = '{1, 64, 30, 64};
    noend   = '{0, 0, 0, 1};
    fill_rom();

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ce_n === 1'b1 && wr_n === 1'b1 && done_n === 1'b1 && err === 1'b0 &&
        cycles == 16'd0 && mem_en === 1'b0, "R1 reset state", {31'h0, ce_n}, 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(ce_n === 1'b1 && done_n === 1'b1 && err === 1'b0 && mem_en === 1'b0,
        "R1 idle after reset", {31'h0, mem_en}, 32'd0);

    // directed corners
    run_xfer(0, 1'b0);     // single-word image
    run_xfer(1, 1'b0);     // end word at last offset, no error
    busy_rand = 1'b1;
    run_xfer(2, 1'b1);     // stalls, selector change, trigger glitch
    busy_rand = 1'b0;
    run_xfer(3, 1'b0);     // no end word: region guard
    run_status(2, 5);      // status read-back end
    run_status(1, 1);      // status end on the very first word

    // constrained random
    for (int it = 0; it < 10; it++) begin
      int  sel;
      bit  gl;
      for (int i = 0; i < NIMG; i++) begin
        elen[i]  = $urandom_range(1, SPAN);
        noend[i] = ($urandom_range(3) == 0);
      end
      fill_rom();
      sel       = $urandom_range(NIMG - 1);
      busy_rand = $urandom_range(1);
      gl        = ((noend[sel] || elen[sel] >= 16) && $urandom_range(1) == 1);
      run_xfer(sel, gl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule